// File: doc/BRIEF.md
# Series FET Body-Diode Guard

A battery pack switches its charge and discharge paths through a pair of main N-channel FETs placed back to back. Smaller precharge and predischarge FETs sit beside them. When protection logic turns one main FET off while the other path is still carrying a large current, that current flows through the off FET's body diode and heats it. This block sits between the FET requests and the gate drivers. When the off FET's body diode would carry a significant current, it turns that FET on for a while. It lets the FET go off again once the current has fallen back through a hysteresis band, as long as the request is still off.

Current arrives as a signed two's-complement sample with a valid strobe. A positive value means charging and a negative value means discharging. Threshold comparisons only take effect on strobed samples. A configuration input chooses between series FETs, where the guard is active, and parallel FETs, where every output follows its request. A four-bit enable mask marks which FETs are fitted. All outputs are registered, so each one settles one clock after the inputs that cause it.

Top module: `fet_diode_guard`

## Requirements
- R1: While `rst` is high, every output and both override flags are low on the clock edge that follows.
- R2: A charge override is set when all of these hold: `series_mode` is 1, `fet_en[0]` is 1, `chg_req` is 0, and the discharge side is conducting (`dsg_req` with `fet_en[1]`, or `pdsg_req` with `fet_en[3]`). In that state, a strobed sample that is negative with a magnitude strictly greater than `dsg_thresh` makes `chg_ovr` and `chg_on` high one clock after the strobe.
- R3: Once set, the charge override holds while strobed discharge magnitudes stay above the release floor. The floor is `dsg_thresh - hyst`, clamped to 0. A strobed sample whose discharge magnitude is at or below the floor clears the override. A positive or zero sample has a discharge magnitude of 0.
- R4: A discharge override mirrors R2. The conditions are `fet_en[1]` set, `dsg_req` at 0, the charge side conducting (`chg_req` with `fet_en[0]`, or `pchg_req` with `fet_en[2]`), and `series_mode` at 1. A strobed positive sample strictly greater than `chg_thresh` then sets `dsg_ovr` and `dsg_on` one clock later.
- R5: The discharge override releases on a strobed sample whose charge magnitude is at or below `chg_thresh - hyst`, clamped to 0. It holds otherwise.
- R6: With `series_mode` at 0, no override is ever set. Each output equals its request ANDed with its enable bit, one clock later.
- R7: A FET whose enable bit is 0 drives its output low and never receives an override. The bit order is 0 charge, 1 discharge, 2 precharge, 3 predischarge.
- R8: Without `cur_valid`, the current sample has no effect, and a cleared override stays cleared.
- R9: If any arming condition of R2 or R4 stops holding, that override clears on the next clock edge, with or without a strobe.
- R10: `pchg_on` and `pdsg_on` follow their request ANDed with their enable bit, one clock later, in both modes.
- R11: `chg_ovr` and `dsg_ovr` report the override state that is applied to `chg_on` and `dsg_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| series_mode | input | 1 | 1 = series FETs (guard active), 0 = parallel |
| fet_en | input | 4 | Fitted-FET mask: bit0 charge, bit1 discharge, bit2 precharge, bit3 predischarge |
| chg_req | input | 1 | Charge FET requested on |
| dsg_req | input | 1 | Discharge FET requested on |
| pchg_req | input | 1 | Precharge FET requested on |
| pdsg_req | input | 1 | Predischarge FET requested on |
| cur_valid | input | 1 | Current sample strobe |
| cur_sample | input | CUR_W | Signed current, positive = charging |
| chg_thresh | input | CUR_W | Charging-current magnitude that arms the discharge override |
| dsg_thresh | input | CUR_W | Discharging-current magnitude that arms the charge override |
| hyst | input | CUR_W | Release hysteresis subtracted from either threshold |
| chg_on | output | 1 | Charge FET gate enable |
| dsg_on | output | 1 | Discharge FET gate enable |
| pchg_on | output | 1 | Precharge FET gate enable |
| pdsg_on | output | 1 | Predischarge FET gate enable |
| chg_ovr | output | 1 | Charge override active |
| dsg_ovr | output | 1 | Discharge override active |

## Verification
The guard is first driven with samples that step across each threshold: one count below it, exactly on it, one above, inside the hysteresis band, and at the release floor. This separates strict from inclusive comparisons in both set and release. Each direction is armed once through a main FET and once through its pre-path FET, which shows that either one counts as conduction. The same currents are then applied in parallel mode, with FETs masked out, with the strobe low, and with a hysteresis larger than the threshold. These runs tell the gating conditions apart from the comparisons. A long stretch of random requests, masks and currents is then checked every clock against a behavioural model.

// File: rtl/fet_diode_guard.sv
module fet_diode_guard #(
  parameter int CUR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    series_mode,
  input  logic [3:0]              fet_en,
  input  logic                    chg_req,
  input  logic                    dsg_req,
  input  logic                    pchg_req,
  input  logic                    pdsg_req,
  input  logic                    cur_valid,
  input  logic signed [CUR_W-1:0] cur_sample,
  input  logic [CUR_W-1:0]        chg_thresh,
  input  logic [CUR_W-1:0]        dsg_thresh,
  input  logic [CUR_W-1:0]        hyst,
  output logic                    chg_on,
  output logic                    dsg_on,
  output logic                    pchg_on,
  output logic                    pdsg_on,
  output logic                    chg_ovr,
  output logic                    dsg_ovr
);
  localparam int CH = 0, DS = 1, PC = 2, PD = 3;

  logic             neg;
  logic [CUR_W-1:0] in_mag, out_mag, in_floor, out_floor;
  logic             in_path, out_path, chg_arm, dsg_arm;
  logic             chg_ovr_d, dsg_ovr_d;

  assign neg       = cur_sample[CUR_W-1];
  assign in_mag    = neg ? '0 : cur_sample;
  assign out_mag   = neg ? (~cur_sample + 1'b1) : '0;
  assign in_floor  = (chg_thresh > hyst) ? chg_thresh - hyst : '0;
  assign out_floor = (dsg_thresh > hyst) ? dsg_thresh - hyst : '0;

  assign in_path  = (chg_req & fet_en[CH]) | (pchg_req & fet_en[PC]);
  assign out_path = (dsg_req & fet_en[DS]) | (pdsg_req & fet_en[PD]);
  assign chg_arm  = series_mode & fet_en[CH] & ~chg_req & out_path;
  assign dsg_arm  = series_mode & fet_en[DS] & ~dsg_req & in_path;

  always_comb begin
    chg_ovr_d = chg_ovr;
    if (!chg_arm) chg_ovr_d = 1'b0;
    else if (cur_valid) begin
      if (out_mag > dsg_thresh)      chg_ovr_d = 1'b1;
      else if (out_mag <= out_floor) chg_ovr_d = 1'b0;
    end
    dsg_ovr_d = dsg_ovr;
    if (!dsg_arm) dsg_ovr_d = 1'b0;
    else if (cur_valid) begin
      if (in_mag > chg_thresh)      dsg_ovr_d = 1'b1;
      else if (in_mag <= in_floor)  dsg_ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {chg_ovr, dsg_ovr}                   <= '0;
      {chg_on, dsg_on, pchg_on, pdsg_on}   <= '0;
    end else begin
      chg_ovr <= chg_ovr_d;
      dsg_ovr <= dsg_ovr_d;
      chg_on  <= fet_en[CH] & (chg_req | chg_ovr_d);
      dsg_on  <= fet_en[DS] & (dsg_req | dsg_ovr_d);
      pchg_on <= fet_en[PC] & pchg_req;
      pdsg_on <= fet_en[PD] & pdsg_req;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !(chg_on || dsg_on || pchg_on || pdsg_on || chg_ovr || dsg_ovr));

  // R2
  chg_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && series_mode && fet_en[0] && !chg_req && cur_sample < 0 &&
     ((dsg_req && fet_en[1]) || (pdsg_req && fet_en[3])) && out_mag > dsg_thresh)
    |=> (chg_ovr && chg_on));

  // R4
  dsg_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && series_mode && fet_en[1] && !dsg_req && cur_sample > 0 &&
     ((chg_req && fet_en[0]) || (pchg_req && fet_en[2])) && in_mag > chg_thresh)
    |=> (dsg_ovr && dsg_on));

  // R6
  parallel_no_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    !series_mode |=> (!chg_ovr && !dsg_ovr));

  // R7
  masked_off_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (({pdsg_on, pchg_on, dsg_on, chg_on} & ~$past(fet_en)) == 4'b0));

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!cur_valid && !chg_ovr && !dsg_ovr) |=> (!chg_ovr && !dsg_ovr));

  // R9
  arm_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_req || dsg_req) |=> !(chg_ovr && $past(chg_req)) && !(dsg_ovr && $past(dsg_req)));

  // R10
  pre_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pchg_req && fet_en[2]) |=> pchg_on);
endmodule

// File: tb/fet_diode_guard_tb.sv
module fet_diode_guard_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic series_mode = 1'b1;
  logic [3:0] fet_en = 4'hF;
  logic chg_req = 1'b1, dsg_req = 1'b1, pchg_req = 1'b1, pdsg_req = 1'b1;
  logic cur_valid = 1'b0;
  logic signed [W-1:0] cur_sample = '0;
  logic [W-1:0] chg_thresh = 16'd800, dsg_thresh = 16'd1000, hyst = 16'd100;
  logic chg_on, dsg_on, pchg_on, pdsg_on, chg_ovr, dsg_ovr;

  always #10 clk = ~clk;

  fet_diode_guard #(.CUR_W(W)) u_dut (
    .clk(clk), .rst(rst), .series_mode(series_mode), .fet_en(fet_en),
    .chg_req(chg_req), .dsg_req(dsg_req), .pchg_req(pchg_req), .pdsg_req(pdsg_req),
    .cur_valid(cur_valid), .cur_sample(cur_sample), .chg_thresh(chg_thresh),
    .dsg_thresh(dsg_thresh), .hyst(hyst), .chg_on(chg_on), .dsg_on(dsg_on),
    .pchg_on(pchg_on), .pdsg_on(pdsg_on), .chg_ovr(chg_ovr), .dsg_ovr(dsg_ovr));

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit m_co, m_do, m_c, m_d, m_pc, m_pd;
  int cur_i, dmag, cmag, dfl, cfl;
  bit armc, armd;

  always @(posedge clk) begin
    if (rst) begin
      {m_co, m_do, m_c, m_d, m_pc, m_pd} = '0;
    end else begin
      cur_i = int'(cur_sample);
      dmag = (cur_i < 0) ? -cur_i : 0;
      cmag = (cur_i > 0) ? cur_i : 0;
      dfl = int'(dsg_thresh) - int'(hyst); if (dfl < 0) dfl = 0;
      cfl = int'(chg_thresh) - int'(hyst); if (cfl < 0) cfl = 0;
      armc = series_mode && fet_en[0] && !chg_req &&
             ((dsg_req && fet_en[1]) || (pdsg_req && fet_en[3]));
      armd = series_mode && fet_en[1] && !dsg_req &&
             ((chg_req && fet_en[0]) || (pchg_req && fet_en[2]));
      if (!armc) m_co = 0;
      else if (cur_valid) begin
        if (dmag > int'(dsg_thresh)) m_co = 1; else if (dmag <= dfl) m_co = 0;
      end
      if (!armd) m_do = 0;
      else if (cur_valid) begin
        if (cmag > int'(chg_thresh)) m_do = 1; else if (cmag <= cfl) m_do = 0;
      end
      m_c  = fet_en[0] && (chg_req || m_co);
      m_d  = fet_en[1] && (dsg_req || m_do);
      m_pc = fet_en[2] && pchg_req;
      m_pd = fet_en[3] && pdsg_req;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    checks++;
    if ({chg_on, dsg_on, pchg_on, pdsg_on, chg_ovr, dsg_ovr} !==
        {m_c, m_d, m_pc, m_pd, m_co, m_do}) begin
      fails++;
      $display("FAIL %s cycle %0d: actual on=%b%b%b%b ovr=%b%b expected on=%b%b%b%b ovr=%b%b",
               tag, cycles, chg_on, dsg_on, pchg_on, pdsg_on, chg_ovr, dsg_ovr,
               m_c, m_d, m_pc, m_pd, m_co, m_do);
    end
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      finish_run();
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sample(input int v);
    cur_sample = W'(v); cur_valid = 1'b1; step(); cur_valid = 1'b0; step();
  endtask

  initial begin
    tag = "R1"; step(3);
    rst = 1'b0; chg_req = 0; dsg_req = 1; pchg_req = 0; pdsg_req = 0; step();
    tag = "R2"; sample(-500); sample(-1000); sample(-1001);
    tag = "R3"; sample(-950); sample(-901); sample(-900); sample(-1200); sample(300);
    tag = "R8"; cur_sample = -16'sd2000; step(3);
    tag = "R2"; dsg_req = 0; pdsg_req = 1; sample(-32768);
    tag = "R9"; pdsg_req = 0; step(2); pdsg_req = 1; sample(-1500); chg_req = 1; step(2);
    tag = "R4"; chg_req = 1; pdsg_req = 0; dsg_req = 0; sample(800); sample(801);
    tag = "R5"; sample(750); sample(701); sample(700); sample(900); sample(-5);
    tag = "R4"; chg_req = 0; pchg_req = 1; sample(2000);
    tag = "R6"; series_mode = 0; step(2); sample(5000); chg_req = 0; dsg_req = 1;
    sample(-5000); series_mode = 1;
    tag = "R7"; fet_en = 4'b1101; dsg_req = 0; pchg_req = 1; chg_req = 1; sample(3000);
    fet_en = 4'b1110; chg_req = 1; dsg_req = 1; sample(-3000); fet_en = 4'hF;
    tag = "R3"; hyst = 16'd2000; chg_req = 0; dsg_req = 1; sample(-1500); sample(-1);
    sample(0);
    tag = "R10"; pchg_req = 1; pdsg_req = 0; step(2); pchg_req = 0; pdsg_req = 1; step(2);
    tag = "R11"; hyst = 16'd100;
    for (int k = 0; k < 2000; k++) begin
      series_mode = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 15) == 0) fet_en = 4'($urandom);
      if ($urandom_range(0, 3) == 0)
        {chg_req, dsg_req, pchg_req, pdsg_req} = 4'($urandom);
      cur_valid = $urandom_range(0, 1) == 1;
      cur_sample = W'($urandom_range(0, 4000)) - 16'sd2000;
      if (k == 1000) rst = 1'b1;
      if (k == 1003) rst = 1'b0;
      step();
    end
    cur_valid = 0; step(2);
    finish_run();
  end
endmodule